// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests from nine sources and presents one interrupt line to a small processor core. Five of the sources are internal to the chip (three timers, two DMA channels) and four arrive on external pins. Each source has a control register that gives it a 3-bit priority level, where 0 is the most urgent, and a mask bit. A global level threshold can silence whole bands of levels. A pending request is latched until it is acknowledged. When the core acknowledges, the winning source's in-service bit is set. Until software clears that bit with an end-of-interrupt write, every request at the same or a less urgent level is held back. More urgent requests still get through, so service routines can nest.

External pins 0 and 1 can each be switched into cascade operation. External pin 2 or 3 is then no longer a request input: an acknowledge of the paired source produces a one-cycle strobe on the matching acknowledge output, meant for a downstream controller, in place of an internal vector. Software reaches all state through a flat register port with 4-bit addresses and 16-bit data. Writes are synchronous and reads are combinational.

Address map: 0 to 8 are the source control registers, indexed by source number. 9 is pending requests, 10 is in-service, 11 is the level threshold, 12 is end-of-interrupt (write only) and 13 is status. Source numbers are: timer0=0, timer1=1, timer2=2, DMA0=3, DMA1=4, external pins 0..3 = 5..8. In the request, in-service and mask views, bit n stands for source n.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, irq_o and vec_valid_o are low, pending and in-service read 0, the status register reads 0, the level threshold reads 8 (nothing blocked), and every control register reads 0x000F: bit 3 mask=1, bits 2:0 level=7, bit 4 cascade=0.
- R2: A request input that is high at a clock edge sets that source's pending bit (address 9). A masked source never raises irq_o. Clearing its mask while the request is still pending raises irq_o.
- R3: Among eligible sources the numerically lowest level wins. Ties go to the lower source number.
- R4: When inta_i is high while irq_o is high, in the next cycle vec_valid_o pulses with vec_o = VEC_BASE + source number (default base 0x20). The winner's in-service bit is set and its pending bit is cleared.
- R5: While any in-service bit is set, a pending source whose level is equal to or greater than the smallest in-service level does not raise irq_o. A source with a strictly smaller level does.
- R6: Writing address 12 with bit 15 = 0 clears the in-service bit of the source number in bits 3:0.
- R7: Writing address 12 with bit 15 = 1 clears the in-service bit of the most urgent in-service source (lowest level, then lowest number).
- R8: With a threshold T at address 11 (bits 3:0), sources whose level is greater than or equal to T do not raise irq_o.
- R9: Bit 4 of control register 5 or 6 puts external pin 0 or 1 in cascade. Pin 2 or 3 requests are then ignored, and acknowledging that source pulses casc_ack_o[0] or [1] for one cycle with no vec_valid_o. Without the cascade bit, pins 2 and 3 are ordinary request inputs.
- R10: inta_i while irq_o is low produces no vector, no acknowledge strobe and no in-service change.
- R11: An acknowledge and an end-of-interrupt write in the same cycle both take effect: the EOI clears its bit and the acknowledge sets the winner's bit.
- R12: The status register (address 13) shows irq_o in bit 4 and the current winner's source number in bits 3:0 (0 when none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_req_i | input | 3 | Timer request levels, bit n = timer n |
| dma_req_i | input | 2 | DMA channel request levels |
| ext_pin_i | input | 4 | External request pins 0..3 |
| casc_ack_o | output | 2 | Dedicated acknowledge strobes for cascaded pins 0 and 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| inta_i | input | 1 | One-cycle acknowledge from the core |
| vec_o | output | 8 | Vector number for the acknowledged source |
| vec_valid_o | output | 1 | vec_o is valid this cycle |

## Verification
An acknowledge and an end-of-interrupt write can land on the same clock edge, and both change the in-service register. The bench arranges this with timer0 in service and DMA0, which is more urgent, pending. It then raises inta_i and writes a specific EOI for timer0 in one cycle. The outcome is judged by the vector returned for DMA0 and by the in-service register, which must then hold only DMA0's bit.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC      = 9;
    localparam int ID_W      = 4;
    localparam int LVL_W     = 3;
    localparam int NPAIR     = 2;
    localparam int CASC_BASE = 5;
    localparam int ACK_BASE  = CASC_BASE + NPAIR;
    localparam int DATA_W    = 16;

    localparam int CFG_CASC_BIT = 4;
    localparam int CFG_MASK_BIT = 3;
    localparam int EOI_NS_BIT   = 15;

    typedef logic [ID_W-1:0]  src_id_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [LVL_W:0]   lvl_ext_t;

    typedef struct packed {
        logic cascade;
        logic masked;
        lvl_t lvl;
    } src_cfg_t;

    typedef struct packed {
        logic    we;
        logic    nonspec;
        src_id_t code;
    } eoi_cmd_t;

    typedef enum logic [ID_W-1:0] {
        REG_REQ  = 4'd9,
        REG_ISR  = 4'd10,
        REG_PLM  = 4'd11,
        REG_EOI  = 4'd12,
        REG_STAT = 4'd13
    } reg_sel_e;

    localparam src_cfg_t CFG_RESET = '{cascade: 1'b0, masked: 1'b1, lvl: '1};
    localparam lvl_ext_t LVL_NONE  = lvl_ext_t'(1 << LVL_W);

    function automatic lvl_ext_t widen(lvl_t l);
        return {1'b0, l};
    endfunction

    function automatic logic [NSRC-1:0] onehot_of(src_id_t id, logic en);
        logic [NSRC-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++)
            if (en && id == src_id_t'(i)) r[i] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] cand_i,
    input  src_cfg_t     cfg_i [N],
    output logic         hit_o,
    output src_id_t      id_o,
    output lvl_ext_t     lvl_o
);

    always_comb begin
        hit_o = 1'b0;
        id_o  = '0;
        lvl_o = LVL_NONE;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (widen(cfg_i[i].lvl) < lvl_o)) begin
                hit_o = 1'b1;
                id_o  = src_id_t'(i);
                lvl_o = widen(cfg_i[i].lvl);
            end
        end
    end

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_nest_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  src_id_t           addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output src_cfg_t          cfg_o [NSRC],
    output lvl_ext_t          plm_o
);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam bit CAN_CASC = (s >= CASC_BASE) && (s < CASC_BASE + NPAIR);
        src_cfg_t cfg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= CFG_RESET;
            end else if (wr_en_i && addr_i == src_id_t'(s)) begin
                cfg_q.cascade <= CAN_CASC ? wdata_i[CFG_CASC_BIT] : 1'b0;
                cfg_q.masked  <= wdata_i[CFG_MASK_BIT];
                cfg_q.lvl     <= wdata_i[LVL_W-1:0];
            end
        end

        assign cfg_o[s] = cfg_q;
    end

    lvl_ext_t plm_q;

    always_ff @(posedge clk) begin
        if (rst)
            plm_q <= LVL_NONE;
        else if (wr_en_i && addr_i == REG_PLM)
            plm_q <= wdata_i[LVL_W:0];
    end

    assign plm_o = plm_q;

endmodule

// File: rtl/irq_service.sv
module irq_service
    import irq_nest_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  raw_req_i,
    input  src_cfg_t         cfg_i [NSRC],
    input  lvl_ext_t         plm_i,
    input  logic             inta_i,
    input  eoi_cmd_t         eoi_i,
    output logic             irq_o,
    output src_id_t          win_id_o,
    output logic [NSRC-1:0]  req_o,
    output logic [NSRC-1:0]  isr_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o,
    output logic [NPAIR-1:0] casc_ack_o
);

    logic [NSRC-1:0]  req_q, isr_q, gated, elig, ack_set, eoi_clr;
    logic [NPAIR-1:0] casc_on, casc_hit;
    logic             isr_hit, take, win_casc;
    src_id_t          isr_top, win_id;
    lvl_ext_t         isr_lvl, win_lvl;
    logic [VEC_W-1:0] vec_q;
    logic             vec_valid_q;
    logic [NPAIR-1:0] casc_ack_q;

    // Pins paired as acknowledge outputs stop acting as requests.
    always_comb begin
        gated = raw_req_i;
        for (int p = 0; p < NPAIR; p++) begin
            casc_on[p] = cfg_i[CASC_BASE + p].cascade;
            if (casc_on[p]) gated[ACK_BASE + p] = 1'b0;
        end
    end

    irq_pick #(.N(NSRC)) u_isr_pick (
        .cand_i (isr_q),
        .cfg_i  (cfg_i),
        .hit_o  (isr_hit),
        .id_o   (isr_top),
        .lvl_o  (isr_lvl)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_elig
        assign elig[s] = req_q[s] && !cfg_i[s].masked
                      && (widen(cfg_i[s].lvl) < plm_i)
                      && (widen(cfg_i[s].lvl) < isr_lvl);
    end

    irq_pick #(.N(NSRC)) u_req_pick (
        .cand_i (elig),
        .cfg_i  (cfg_i),
        .hit_o  (irq_o),
        .id_o   (win_id),
        .lvl_o  (win_lvl)
    );

    assign take    = inta_i && irq_o;
    assign ack_set = onehot_of(win_id, take);

    always_comb begin
        if (!eoi_i.we)
            eoi_clr = '0;
        else if (eoi_i.nonspec)
            eoi_clr = onehot_of(isr_top, isr_hit);
        else
            eoi_clr = onehot_of(eoi_i.code, 1'b1);
    end

    always_comb begin
        for (int p = 0; p < NPAIR; p++)
            casc_hit[p] = casc_on[p] && (win_id == src_id_t'(CASC_BASE + p));
        win_casc = |casc_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q       <= '0;
            isr_q       <= '0;
            vec_q       <= '0;
            vec_valid_q <= 1'b0;
            casc_ack_q  <= '0;
        end else begin
            req_q       <= (req_q & ~ack_set) | gated;
            isr_q       <= (isr_q & ~eoi_clr) | ack_set;
            vec_valid_q <= take && !win_casc;
            casc_ack_q  <= take ? casc_hit : '0;
            if (take)
                vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_id);
        end
    end

    assign win_id_o    = win_id;
    assign req_o       = req_q;
    assign isr_o       = isr_q;
    assign vec_o       = vec_q;
    assign vec_valid_o = vec_valid_q;
    assign casc_ack_o  = casc_ack_q;

    AST_ISR_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> isr_q[$past(win_id)]) else $error("isr not set");  // R4
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !isr_q[win_id]) else $error("reentry");  // R5
    AST_EOI_SPEC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (eoi_i.we && !eoi_i.nonspec && eoi_i.code < src_id_t'(NSRC)
         && !(take && win_id == eoi_i.code))
        |=> !isr_q[$past(eoi_i.code)]) else $error("eoi miss");  // R6
    AST_PLM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (win_lvl < plm_i)) else $error("plm leak");  // R8
    AST_ACK_KIND_EXCL: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> (casc_ack_o == '0)) else $error("both acks");  // R9
    AST_CASC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(casc_ack_o)) else $error("two casc acks");  // R9
    AST_VEC_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> $past(inta_i && irq_o)) else $error("stray vec");  // R10

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        tmr_req_i,
    input  logic [1:0]        dma_req_i,
    input  logic [3:0]        ext_pin_i,
    output logic [NPAIR-1:0]  casc_ack_o,
    input  logic              reg_we_i,
    input  logic [ID_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    input  logic              inta_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_valid_o
);

    src_cfg_t        cfg [NSRC];
    lvl_ext_t        plm;
    eoi_cmd_t        eoi;
    src_id_t         win_id;
    logic [NSRC-1:0] req_bits, isr_bits;

    irq_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .cfg_o   (cfg),
        .plm_o   (plm)
    );

    assign eoi.we      = reg_we_i && (reg_addr_i == REG_EOI);
    assign eoi.nonspec = reg_wdata_i[EOI_NS_BIT];
    assign eoi.code    = reg_wdata_i[ID_W-1:0];

    irq_service #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_svc (
        .clk         (clk),
        .rst         (rst),
        .raw_req_i   ({ext_pin_i, dma_req_i, tmr_req_i}),
        .cfg_i       (cfg),
        .plm_i       (plm),
        .inta_i      (inta_i),
        .eoi_i       (eoi),
        .irq_o       (irq_o),
        .win_id_o    (win_id),
        .req_o       (req_bits),
        .isr_o       (isr_bits),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o),
        .casc_ack_o  (casc_ack_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        for (int s = 0; s < NSRC; s++)
            if (reg_addr_i == src_id_t'(s))
                reg_rdata_o = DATA_W'({cfg[s].cascade, cfg[s].masked, cfg[s].lvl});
        case (reg_addr_i)
            REG_REQ:  reg_rdata_o = DATA_W'(req_bits);
            REG_ISR:  reg_rdata_o = DATA_W'(isr_bits);
            REG_PLM:  reg_rdata_o = DATA_W'(plm);
            REG_STAT: reg_rdata_o = DATA_W'({irq_o, win_id});
            default:  ;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && !vec_valid_o && casc_ack_o == '0)) else $error("reset");  // R1

endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

    localparam int OP_WR = 0, OP_RD = 1, OP_PIN = 2, OP_IRQ = 3, OP_ACK = 4;
    localparam int NV = 80;

    function automatic logic [26:0] v(int op, int addr, int data, int tag);
        return {3'(op), 4'(addr), 16'(data), 4'(tag)};
    endfunction

    // ACK expected data: bit15 vec_valid, bits9:8 casc_ack, bits7:0 vector
    localparam logic [26:0] TBL [NV] = '{
        v(OP_RD, 0, 16'h000F, 1),   // R1 reset cfg
        v(OP_RD, 11, 16'h0008, 1),  // R1 threshold
        v(OP_RD, 10, 16'h0000, 1),  // R1 isr
        v(OP_RD, 9, 16'h0000, 1),   // R1 req
        v(OP_IRQ, 0, 0, 1),         // R1
        v(OP_RD, 13, 16'h0000, 1),  // R1 status
        v(OP_PIN, 0, 16'h0001, 2),  // R2 timer0 high
        v(OP_IRQ, 0, 0, 2),         // R2 masked
        v(OP_RD, 9, 16'h0001, 2),   // R2 latched
        v(OP_WR, 0, 16'h0003, 2),   // unmask lvl3
        v(OP_IRQ, 0, 1, 2),         // R2
        v(OP_PIN, 0, 0, 2),
        v(OP_RD, 13, 16'h0010, 12), // R12
        v(OP_ACK, 0, 16'h8020, 4),  // R4
        v(OP_RD, 10, 16'h0001, 4),  // R4 isr set
        v(OP_RD, 9, 16'h0000, 4),   // R4 req cleared
        v(OP_IRQ, 0, 0, 5),
        v(OP_WR, 1, 16'h0005, 5),
        v(OP_WR, 3, 16'h0001, 5),
        v(OP_PIN, 0, 16'h0002, 5),
        v(OP_PIN, 0, 0, 5),
        v(OP_IRQ, 0, 0, 5),         // R5 lower blocked
        v(OP_PIN, 0, 16'h0008, 5),
        v(OP_PIN, 0, 0, 5),
        v(OP_IRQ, 0, 1, 5),         // R5 higher passes
        v(OP_RD, 13, 16'h0013, 5),
        v(OP_ACK, 0, 16'h8023, 5),
        v(OP_RD, 10, 16'h0009, 4),
        v(OP_IRQ, 0, 0, 5),
        v(OP_WR, 12, 16'h8000, 7),
        v(OP_RD, 10, 16'h0001, 7),  // R7
        v(OP_IRQ, 0, 0, 5),
        v(OP_WR, 12, 16'h0000, 6),
        v(OP_RD, 10, 16'h0000, 6),  // R6
        v(OP_IRQ, 0, 1, 6),
        v(OP_RD, 13, 16'h0011, 12),
        v(OP_WR, 11, 16'h0005, 8),
        v(OP_IRQ, 0, 0, 8),         // R8
        v(OP_WR, 11, 16'h0006, 8),
        v(OP_IRQ, 0, 1, 8),         // R8
        v(OP_ACK, 0, 16'h8021, 4),
        v(OP_WR, 12, 16'h0001, 6),
        v(OP_RD, 10, 16'h0000, 6),
        v(OP_WR, 2, 16'h0002, 3),
        v(OP_WR, 4, 16'h0002, 3),
        v(OP_PIN, 0, 16'h0014, 3),
        v(OP_PIN, 0, 0, 3),
        v(OP_RD, 13, 16'h0012, 3),  // R3 tie
        v(OP_WR, 4, 16'h0001, 3),
        v(OP_RD, 13, 16'h0014, 3),  // R3 level
        v(OP_ACK, 0, 16'h8024, 3),
        v(OP_RD, 13, 16'h0000, 5),
        v(OP_WR, 12, 16'h8000, 7),
        v(OP_RD, 13, 16'h0012, 7),
        v(OP_ACK, 0, 16'h8022, 4),
        v(OP_WR, 12, 16'h8000, 7),
        v(OP_RD, 10, 16'h0000, 7),
        v(OP_WR, 5, 16'h0012, 9),   // R9 cascade pair 0
        v(OP_WR, 7, 16'h0000, 9),
        v(OP_PIN, 0, 16'h00A0, 9),
        v(OP_PIN, 0, 0, 9),
        v(OP_RD, 9, 16'h0020, 9),   // R9 pin2 ignored
        v(OP_RD, 13, 16'h0015, 9),
        v(OP_ACK, 0, 16'h0100, 9),  // R9 strobe
        v(OP_RD, 10, 16'h0020, 9),
        v(OP_WR, 12, 16'h0005, 6),
        v(OP_RD, 10, 16'h0000, 6),
        v(OP_WR, 6, 16'h0001, 9),
        v(OP_PIN, 0, 16'h0040, 9),
        v(OP_PIN, 0, 0, 9),
        v(OP_ACK, 0, 16'h8026, 9),  // R9 non-cascade pair
        v(OP_WR, 12, 16'h8000, 7),
        v(OP_WR, 5, 16'h0002, 9),
        v(OP_PIN, 0, 16'h0080, 9),
        v(OP_PIN, 0, 0, 9),
        v(OP_ACK, 0, 16'h8027, 9),  // R9 pin2 direct
        v(OP_WR, 12, 16'h8000, 7),
        v(OP_IRQ, 0, 0, 10),
        v(OP_ACK, 0, 16'h0000, 10), // R10
        v(OP_RD, 10, 16'h0000, 10)  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  tmr = '0;
    logic [1:0]  dma = '0;
    logic [3:0]  ext = '0;
    logic [1:0]  casc_ack;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        inta = 1'b0;
    logic [7:0]  vec;
    logic        vec_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_nest_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .tmr_req_i   (tmr),
        .dma_req_i   (dma),
        .ext_pin_i   (ext),
        .casc_ack_o  (casc_ack),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .inta_i      (inta),
        .vec_o       (vec),
        .vec_valid_o (vec_valid)
    );

    task automatic check(logic ok, int tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic [26:0] e);
        int op, a, d, tag;
        logic [15:0] got;
        op  = int'(e[26:24]);
        a   = int'(e[23:20]);
        d   = int'(e[19:4]);
        tag = int'(e[3:0]);
        @(negedge clk);
        case (op)
            OP_WR: begin
                we = 1'b1; addr = 4'(a); wdata = 16'(d);
                @(posedge clk); #1 we = 1'b0;
            end
            OP_RD: begin
                addr = 4'(a); #1;
                check(rdata == 16'(d), tag, int'(rdata), d);
            end
            OP_PIN: begin
                tmr = d[2:0]; dma = d[4:3]; ext = d[8:5];
                @(posedge clk); #1;
            end
            OP_IRQ: begin
                #1 check(irq == d[0], tag, int'(irq), d & 1);
            end
            default: begin
                inta = 1'b1;
                @(posedge clk); #1 inta = 1'b0;
                got = {vec_valid, 5'b0, casc_ack, (d[15] ? vec : 8'h00)};
                check(got == 16'(d), tag, int'(got), d);
            end
        endcase
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check(!vec_valid && casc_ack == 2'b00, 1, int'({vec_valid, casc_ack}), 0);  // R1
        for (int i = 0; i < NV; i++) step(TBL[i]);

        // R11: acknowledge and specific EOI in the same cycle
        step(v(OP_PIN, 0, 16'h0001, 11));
        step(v(OP_PIN, 0, 0, 11));
        step(v(OP_ACK, 0, 16'h8020, 11));
        step(v(OP_PIN, 0, 16'h0008, 11));
        step(v(OP_PIN, 0, 0, 11));
        step(v(OP_IRQ, 0, 1, 11));
        @(negedge clk);
        inta = 1'b1; we = 1'b1; addr = 4'd12; wdata = 16'h0000;
        @(posedge clk); #1 inta = 1'b0; we = 1'b0;
        check(vec_valid && vec == 8'h23, 11, int'({vec_valid, vec}), 16'h0123);  // R11
        step(v(OP_RD, 10, 16'h0008, 11));  // R11 only DMA0 in service
        step(v(OP_WR, 12, 16'h8000, 7));
        step(v(OP_RD, 10, 16'h0000, 7));

        // R1: reset in mid-run restores defaults
        step(v(OP_PIN, 0, 16'h0008, 1));
        step(v(OP_IRQ, 0, 1, 1));
        @(negedge clk) rst = 1'b1;
        tmr = '0; dma = '0; ext = '0;
        @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        step(v(OP_IRQ, 0, 0, 1));
        step(v(OP_RD, 3, 16'h000F, 1));
        step(v(OP_RD, 9, 16'h0000, 1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule